// File: doc/BRIEF.md
# Tiled Aperture Window Matcher

This block holds a bank of fence entries. Each entry marks one tiled window inside a linear graphics aperture. A host programs every 64-bit entry as two 32-bit halves through a plain write strobe, and it can read any half back. Each cycle the block takes one aperture address and compares it against every entry at once. It reports whether the address lies in an enabled window. On a hit it also gives the row pitch and the tiling kind of that window, and the byte offset of the address from the window start.

Software must be able to reprogram an entry without a half-written entry ever being used. The enable bit therefore sits in the low half. The expected sequence is: write zero to the low half, write the high half, then write the low half with the enable bit set. When several windows overlap an address, the lowest-numbered entry wins, and a flag shows that more than one entry matched.

Top module: `fence_window_match`

## Requirements
- R1: After reset every entry is zero: no lookup hits, and every half reads back as zero.
- R2: A write to select `{index, half}` stores the data in that half of that entry from the next clock edge. Half bit 0 selects the low word and half bit 1 selects the high word. A read of the same select returns the stored word combinationally.
- R3: An address hits an entry when all three hold: low-word bit 0 (enable) is set, address[31:12] >= low[31:12] (first page), and address[31:12] <= high[31:12] (last page). Every byte from the first page up to the end of the last 4 KiB page matches.
- R4: On a hit, `hit_pitch` equals low[11:2] of the winning entry, which holds the stride divided by 128, minus one. `hit_ytile` equals low[1], where 1 means Y tiling and 0 means X tiling.
- R5: On a hit, `hit_offset` equals the address minus {low[31:12], 12'h000}.
- R6: When several entries hit, `hit_idx` is the lowest matching index and `multi_hit` is 1. When exactly one entry hits, `multi_hit` is 0.
- R7: With no hit, `hit_idx`, `hit_pitch`, `hit_ytile`, `hit_offset` and `multi_hit` are all zero.
- R8: Writing zero to a low word disables that entry for lookups from the next clock edge. A high-word write to a disabled entry has no effect on lookups until the low word is written again with the enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | $clog2(N_FENCE)+1 | Write select: {entry index, half}, half 1 = high word |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | $clog2(N_FENCE)+1 | Read select, same encoding as reg_sel |
| reg_rdata | output | 32 | Stored word at reg_rsel |
| lookup_addr | input | 32 | Aperture address to classify |
| hit | output | 1 | Address lies in an enabled window |
| hit_idx | output | $clog2(N_FENCE) | Winning entry index |
| hit_pitch | output | 10 | Pitch field of the winning entry |
| hit_ytile | output | 1 | 1 = Y tiling, 0 = X tiling |
| hit_offset | output | 32 | Byte offset from the window start |
| multi_hit | output | 1 | More than one entry matched |

## Verification
All lookup results are combinational from `lookup_addr` and the stored entries. A new address therefore yields its result within the same cycle, and the bench samples one time unit after driving it, well clear of any clock edge. A register write changes the stored state only at the next rising edge. Checks on read-back data, and on lookups that depend on a write (the disable and re-enable steps), are made after that edge has passed.

// File: rtl/fence_window_match.sv
module fence_window_match #(
  parameter int N_FENCE = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_we,
  input  logic [$clog2(N_FENCE):0]   reg_sel,
  input  logic [31:0]                reg_wdata,
  input  logic [$clog2(N_FENCE):0]   reg_rsel,
  output logic [31:0]                reg_rdata,
  input  logic [31:0]                lookup_addr,
  output logic                       hit,
  output logic [$clog2(N_FENCE)-1:0] hit_idx,
  output logic [9:0]                 hit_pitch,
  output logic                       hit_ytile,
  output logic [31:0]                hit_offset,
  output logic                       multi_hit
);
  localparam int IW = $clog2(N_FENCE);
  localparam int PG = 12;

  logic [31:0] lo_q [N_FENCE];
  logic [31:0] hi_q [N_FENCE];
  logic [N_FENCE-1:0] match;
  logic [IW-1:0] win;
  logic any, many;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_FENCE; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
    end else if (reg_we) begin
      if (reg_sel[0]) hi_q[reg_sel[IW:1]] <= reg_wdata;
      else            lo_q[reg_sel[IW:1]] <= reg_wdata;
    end
  end

  assign reg_rdata = reg_rsel[0] ? hi_q[reg_rsel[IW:1]] : lo_q[reg_rsel[IW:1]];

  for (genvar g = 0; g < N_FENCE; g++) begin : g_cmp
    assign match[g] = lo_q[g][0]
                    && (lookup_addr[31:PG] >= lo_q[g][31:PG])
                    && (lookup_addr[31:PG] <= hi_q[g][31:PG]);
  end

  always_comb begin
    win  = '0;
    any  = 1'b0;
    many = 1'b0;
    for (int i = 0; i < N_FENCE; i++) begin
      if (match[i]) begin
        if (any) many = 1'b1;
        else     win  = IW'(i);
        any = 1'b1;
      end
    end
  end

  logic [31:0] win_lo;
  assign win_lo     = lo_q[win];
  assign hit        = any;
  assign multi_hit  = many;
  assign hit_idx    = any ? win : '0;
  assign hit_pitch  = any ? win_lo[11:2] : '0;
  assign hit_ytile  = any & win_lo[1];
  assign hit_offset = any ? lookup_addr - {win_lo[31:PG], {PG{1'b0}}} : '0;
endmodule

// File: rtl/fence_window_match_chk.sv
module fence_window_match_chk #(
  parameter int N_FENCE = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       reg_we,
  input logic [$clog2(N_FENCE):0]   reg_sel,
  input logic [31:0]                reg_wdata,
  input logic [$clog2(N_FENCE):0]   reg_rsel,
  input logic [31:0]                reg_rdata,
  input logic [31:0]                lookup_addr,
  input logic                       hit,
  input logic [$clog2(N_FENCE)-1:0] hit_idx,
  input logic [9:0]                 hit_pitch,
  input logic                       hit_ytile,
  input logic [31:0]                hit_offset,
  input logic                       multi_hit
);
  p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !hit);

  p_readback_r2: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (reg_rsel != $past(reg_sel)) || (reg_rdata == $past(reg_wdata)));

  p_page_offset_r5: assert property (@(posedge clk) disable iff (rst)
    hit |-> hit_offset[11:0] == lookup_addr[11:0]);

  p_multi_needs_hit_r6: assert property (@(posedge clk) disable iff (rst)
    multi_hit |-> hit);

  p_quiet_on_miss_r7: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (hit_offset == 0 && hit_pitch == 0 && !hit_ytile && hit_idx == 0));
endmodule

bind fence_window_match fence_window_match_chk #(.N_FENCE(N_FENCE)) u_chk (.*);

// File: tb/sim_fence_window_match.sv
`timescale 1ns/1ps
module sim_fence_window_match;
  localparam int N = 8;
  logic clk = 0, rst = 1, reg_we = 0;
  logic [3:0] reg_sel = 0, reg_rsel = 0;
  logic [31:0] reg_wdata = 0, lookup_addr = 0, reg_rdata, hit_offset;
  logic hit, hit_ytile, multi_hit;
  logic [2:0] hit_idx;
  logic [9:0] hit_pitch;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fence_window_match #(.N_FENCE(N)) u0 (.*);

  // addr, hit, idx, pitch, ytile, offset, multi
  localparam logic [79:0] TBL [11] = '{
    {32'h000F_FFFF, 1'b0, 3'd0, 10'd0,   1'b0, 32'h0,        1'b0},
    {32'h0010_0000, 1'b1, 3'd0, 10'd3,   1'b0, 32'h0,        1'b0},
    {32'h0010_1234, 1'b1, 3'd0, 10'd3,   1'b0, 32'h1234,     1'b0},
    {32'h0010_2000, 1'b1, 3'd0, 10'd3,   1'b0, 32'h2000,     1'b1},
    {32'h0010_3FFF, 1'b1, 3'd0, 10'd3,   1'b0, 32'h3FFF,     1'b1},
    {32'h0010_4000, 1'b1, 3'd1, 10'd7,   1'b1, 32'h2000,     1'b0},
    {32'h0010_5FFF, 1'b1, 3'd1, 10'd7,   1'b1, 32'h3FFF,     1'b0},
    {32'h0010_6000, 1'b0, 3'd0, 10'd0,   1'b0, 32'h0,        1'b0},
    {32'h8000_0000, 1'b1, 3'd2, 10'h3FF, 1'b1, 32'h0,        1'b0},
    {32'hFFFF_FFFF, 1'b1, 3'd2, 10'h3FF, 1'b1, 32'h7FFF_FFFF, 1'b0},
    {32'h7FFF_FFFF, 1'b0, 3'd0, 10'd0,   1'b0, 32'h0,        1'b0}
  };

  task automatic chk(string req, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, bit high, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = {idx[2:0], high}; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  function automatic logic [79:0] obs();
    return {lookup_addr, hit, hit_idx, hit_pitch, hit_ytile, hit_offset, multi_hit};
  endfunction

  task automatic look(string req, logic [79:0] row);
    lookup_addr = row[79:48];
    #1;
    chk(req, obs(), row);
  endtask

  initial begin
    #20000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    lookup_addr = 32'h0010_0000; #1;
    chk("R1 no hit", {79'd0, hit}, 80'd0);
    for (int s = 0; s < 16; s++) begin
      reg_rsel = s[3:0]; #1;
      chk("R1 readback zero", {48'd0, reg_rdata}, 80'd0);
    end
    // program with the disable / high / low order
    wr(0, 0, 0); wr(0, 1, 32'h0010_3000); wr(0, 0, 32'h0010_000D);
    wr(1, 0, 0); wr(1, 1, 32'h0010_5000); wr(1, 0, 32'h0010_201F);
    wr(2, 0, 0); wr(2, 1, 32'hFFFF_F000); wr(2, 0, 32'h8000_0FFF);
    // R2 readback
    reg_rsel = 4'b0001; #1; chk("R2 high word", {48'd0, reg_rdata}, {48'd0, 32'h0010_3000});
    reg_rsel = 4'b0010; #1; chk("R2 low word",  {48'd0, reg_rdata}, {48'd0, 32'h0010_201F});
    reg_rsel = 4'b0101; #1; chk("R2 high word 2", {48'd0, reg_rdata}, {48'd0, 32'hFFFF_F000});
    // R3 R4 R5 R6 R7 table walk
    for (int i = 0; i < 11; i++) look("R3/R4/R5/R6/R7 table", TBL[i]);
    // R8 disable entry 0 via zero low word
    wr(0, 0, 0);
    look("R8 disabled entry skipped", {32'h0010_2000, 1'b1, 3'd1, 10'd7, 1'b1, 32'h0, 1'b0});
    look("R8 disabled miss", {32'h0010_1000, 1'b0, 3'd0, 10'd0, 1'b0, 32'h0, 1'b0});
    wr(0, 1, 32'h0010_0000);
    look("R8 high write alone no effect", {32'h0010_0000, 1'b0, 3'd0, 10'd0, 1'b0, 32'h0, 1'b0});
    wr(0, 0, 32'h0010_0001);
    look("R8 re-enabled one page", {32'h0010_0FFF, 1'b1, 3'd0, 10'd0, 1'b0, 32'hFFF, 1'b0});
    look("R3 past last page", {32'h0010_1000, 1'b0, 3'd0, 10'd0, 1'b0, 32'h0, 1'b0});
    // R6 highest index alone
    wr(7, 1, 32'h0000_0000); wr(7, 0, 32'h0000_0005);
    look("R6 top entry", {32'h0000_0ABC, 1'b1, 3'd7, 10'd1, 1'b0, 32'hABC, 1'b0});
    // R1 reset again clears
    @(negedge clk); rst = 1; @(posedge clk); #1 rst = 0;
    look("R1 reset clears", {32'h8000_0000, 1'b0, 3'd0, 10'd0, 1'b0, 32'h0, 1'b0});
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule